// File: doc/BRIEF.md
# Program Counter Branch Unit

This unit holds a 64-bit instruction counter and works out its next value for each instruction offered to it. An instruction that is not a branch advances the counter by one. A group of eight branch opcodes either loads an absolute target or adds a signed displacement to the counter. Each branch is unconditional, depends on the equal flag being set or clear, or depends on a 64-bit source operand being nonzero. The counter changes only in cycles where the instruction is marked valid. Fetch, flag generation and operand reads happen elsewhere; this unit only sees the current instruction's fields and the flag.

The destination operand gives the jump target or the displacement. The size field selects how many of its low bits are used: 8, 16, 32 or 64. Absolute targets are zero-extended and kept internally as target minus one. The shared sequential incrementer then adds the one back. Relative displacements are sign-extended and added to the counter directly, with no extra step. Each valid cycle takes one of four routes. HOLD: no valid instruction, so the counter keeps its value. STEP: a non-branch, or a branch whose condition fails, so the counter goes to counter + 1. ABS: a taken absolute jump, so the counter goes to the target. REL: a taken relative jump, so the counter goes to counter + displacement. The route is chosen again from the inputs in every cycle. Any route can follow any other.

Top module: `pcs_unit`

## Requirements
- R1: While `rst_n` is low the counter is held at 0, and it reads 0 in the first cycle after release.
- R2: In a cycle with `instr_valid` low the counter keeps its value, whatever the other inputs carry.
- R3: A valid opcode outside 0x038..0x03F sets the counter to counter + 1.
- R4: Opcode 0x038 loads the counter with the destination operand zero-extended from the width chosen by `size_sel` (00 = 8, 01 = 16, 10 = 32, 11 = 64 bits). Bits above that width are ignored.
- R5: Opcode 0x039 takes the absolute jump of R4 only when `eq_flag` is 1, and 0x03A only when it is 0. A branch that is not taken gives counter + 1.
- R6: Opcode 0x03B takes the absolute jump of R4 only when all 64 bits of `src_opnd` are not all zero, regardless of `size_sel` and `eq_flag`. Otherwise it gives counter + 1.
- R7: Opcode 0x03C sets the counter to counter + the destination operand sign-extended from the width chosen by `size_sel` (same encoding as R4), with no extra +1.
- R8: Opcode 0x03D applies the displacement of R7 only when `eq_flag` is 1, and 0x03E only when it is 0. Otherwise it gives counter + 1.
- R9: Opcode 0x03F applies the displacement of R7 only when `src_opnd` is nonzero over all 64 bits. Otherwise it gives counter + 1.
- R10: All counter arithmetic wraps modulo 2^64: the step from all-ones gives 0, and a displacement past either end wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction is offered this cycle |
| opcode | input | 12 | Instruction opcode |
| size_sel | input | 2 | Operand width select for target or displacement |
| dst_opnd | input | 64 | Absolute target or signed displacement |
| src_opnd | input | 64 | Condition operand for the source-tested branches |
| eq_flag | input | 1 | Equal flag from the compare logic |
| pc | output | 64 | Current instruction counter |

## Verification
Two conditions can be presented in the same cycle: the equal flag and a nonzero source. The stimulus drives both with opposing values, for example the flag set with the source zero for a source-tested branch. This shows that only the condition named by the opcode decides. The same applies to absolute targets and relative displacements whose operands carry garbage above the selected width. Those upper bits must be dropped for an absolute target and replaced by sign copies for a displacement. A behavioural model in the bench computes the expected counter for each cycle, wrapped displacements included, and compares it with `pc` on every clock.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int SIZE_W    = 2;
    localparam int NUM_SIZES = 1 << SIZE_W;
    localparam int LANE_MIN  = 8;

    // first opcode of the eight-entry branch group
    localparam logic [11:0] BR_GROUP_BASE = 12'h038;

    // condition select, taken from the two low opcode bits
    typedef enum logic [1:0] {
        COND_ALWAYS = 2'b00,
        COND_EQ_SET = 2'b01,
        COND_EQ_CLR = 2'b10,
        COND_SRC_NZ = 2'b11
    } cond_e;

    // route chosen for the next counter value
    typedef enum logic [1:0] {
        RT_HOLD = 2'b00,
        RT_STEP = 2'b01,
        RT_ABS  = 2'b10,
        RT_REL  = 2'b11
    } route_e;

    typedef struct packed {
        logic  is_branch;
        logic  is_rel;
        cond_e cond;
    } br_dec_t;

endpackage

// File: rtl/pcs_opdecode.sv
module pcs_opdecode
    import pcs_pkg::*;
#(
    parameter int OPC_W = 12
) (
    input  logic [OPC_W-1:0] opcode_i,
    output br_dec_t          dec_o
);

    localparam logic [OPC_W-1:0] GROUP = OPC_W'(BR_GROUP_BASE);

    always_comb begin
        dec_o.is_branch = (opcode_i[OPC_W-1:3] == GROUP[OPC_W-1:3]);
        dec_o.is_rel    = opcode_i[2];
        dec_o.cond      = cond_e'(opcode_i[1:0]);
    end

endmodule

// File: rtl/pcs_operand_ext.sv
module pcs_operand_ext
    import pcs_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [SIZE_W-1:0] size_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] zext_o,
    output logic [DATA_W-1:0] sext_o
);

    logic [DATA_W-1:0] zx_lane [NUM_SIZES];
    logic [DATA_W-1:0] sx_lane [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int LW = LANE_MIN << g;
        localparam logic [DATA_W-1:0] LMASK = {DATA_W{1'b1}} >> (DATA_W - LW);
        assign zx_lane[g] = opnd_i & LMASK;
        assign sx_lane[g] = (opnd_i & LMASK) | (opnd_i[LW-1] ? ~LMASK : '0);
    end

    assign zext_o = zx_lane[size_i];
    assign sext_o = sx_lane[size_i];

endmodule

// File: rtl/pcs_cond_eval.sv
module pcs_cond_eval
    import pcs_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  cond_e             cond_i,
    input  logic              eq_flag_i,
    input  logic [DATA_W-1:0] src_i,
    output logic              take_o
);

    logic src_nz;
    assign src_nz = |src_i;

    always_comb begin
        unique case (cond_i)
            COND_ALWAYS: take_o = 1'b1;
            COND_EQ_SET: take_o = eq_flag_i;
            COND_EQ_CLR: take_o = ~eq_flag_i;
            COND_SRC_NZ: take_o = src_nz;
        endcase
    end

endmodule

// File: rtl/pcs_unit.sv
module pcs_unit
    import pcs_pkg::*;
#(
    parameter int PC_W  = 64,
    parameter int OPC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [SIZE_W-1:0] size_sel,
    input  logic [PC_W-1:0]   dst_opnd,
    input  logic [PC_W-1:0]   src_opnd,
    input  logic              eq_flag,
    output logic [PC_W-1:0]   pc
);

    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    br_dec_t         dec;
    logic            take;
    logic [PC_W-1:0] tgt_zext;
    logic [PC_W-1:0] off_sext;
    route_e          route;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] seq_base;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] rel_pc;

    pcs_opdecode #(.OPC_W(OPC_W)) u_dec (
        .opcode_i (opcode),
        .dec_o    (dec)
    );

    pcs_operand_ext #(.DATA_W(PC_W)) u_ext (
        .size_i (size_sel),
        .opnd_i (dst_opnd),
        .zext_o (tgt_zext),
        .sext_o (off_sext)
    );

    pcs_cond_eval #(.DATA_W(PC_W)) u_cond (
        .cond_i    (dec.cond),
        .eq_flag_i (eq_flag),
        .src_i     (src_opnd),
        .take_o    (take)
    );

    // route selection
    always_comb begin
        if (!instr_valid)
            route = RT_HOLD;
        else if (!dec.is_branch || !take)
            route = RT_STEP;
        else if (dec.is_rel)
            route = RT_REL;
        else
            route = RT_ABS;
    end

    // absolute targets are parked one below and share the step adder
    assign seq_base = (route == RT_ABS) ? (tgt_zext - ONE) : pc_q;
    assign seq_pc   = seq_base + ONE;
    assign rel_pc   = pc_q + off_sext;

    always_comb begin
        unique case (route)
            RT_HOLD: pc_d = pc_q;
            RT_STEP: pc_d = seq_pc;
            RT_ABS:  pc_d = seq_pc;
            RT_REL:  pc_d = rel_pc;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc_q <= '0;
        else
            pc_q <= pc_d;
    end

    assign pc = pc_q;

endmodule

// File: rtl/pcs_unit_chk.sv
module pcs_unit_chk
    import pcs_pkg::*;
#(
    parameter int PC_W  = 64,
    parameter int OPC_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [OPC_W-1:0]  opcode,
    input logic [SIZE_W-1:0] size_sel,
    input logic [PC_W-1:0]   dst_opnd,
    input logic [PC_W-1:0]   src_opnd,
    input logic              eq_flag,
    input logic [PC_W-1:0]   pc
);

    localparam logic [OPC_W-1:0] OP_LO  = OPC_W'(12'h038);
    localparam logic [OPC_W-1:0] OP_HI  = OPC_W'(12'h03F);
    localparam logic [OPC_W-1:0] OP_JEQ = OPC_W'(12'h039);
    localparam logic [OPC_W-1:0] OP_JSN = OPC_W'(12'h03B);
    localparam logic [OPC_W-1:0] OP_REL = OPC_W'(12'h03C);
    localparam logic [OPC_W-1:0] OP_RSN = OPC_W'(12'h03F);
    localparam logic [PC_W-1:0]  ONE    = PC_W'(1);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> pc == '0);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(pc));

    // R3
    plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && (opcode < OP_LO || opcode > OP_HI) |=> pc == $past(pc) + ONE);

    // R4
    abs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && opcode == OP_LO && size_sel == 2'b00
        |=> pc == {{(PC_W-8){1'b0}}, $past(dst_opnd[7:0])});

    // R5
    eq_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && opcode == OP_JEQ && !eq_flag |=> pc == $past(pc) + ONE);

    // R6
    src_zero_abs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && opcode == OP_JSN && src_opnd == '0 |=> pc == $past(pc) + ONE);

    // R7
    rel_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && opcode == OP_REL && size_sel == 2'b11
        |=> pc == $past(pc) + $past(dst_opnd));

    // R9
    src_zero_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && opcode == OP_RSN && src_opnd == '0 |=> pc == $past(pc) + ONE);

endmodule

bind pcs_unit pcs_unit_chk #(.PC_W(PC_W), .OPC_W(OPC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .opcode      (opcode),
    .size_sel    (size_sel),
    .dst_opnd    (dst_opnd),
    .src_opnd    (src_opnd),
    .eq_flag     (eq_flag),
    .pc          (pc)
);

// File: tb/sim_pcs_unit.sv
module sim_pcs_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [11:0] opcode = '0;
    logic [1:0]  size_sel = '0;
    logic [63:0] dst_opnd = '0;
    logic [63:0] src_opnd = '0;
    logic        eq_flag = 1'b0;
    logic [63:0] pc;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [63:0] exp_pc = '0;
    string       exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pcs_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .opcode      (opcode),
        .size_sel    (size_sel),
        .dst_opnd    (dst_opnd),
        .src_opnd    (src_opnd),
        .eq_flag     (eq_flag),
        .pc          (pc)
    );

    function automatic logic [63:0] ref_next(input logic [63:0] cur, input bit v,
            input logic [11:0] op, input logic [1:0] sz, input logic [63:0] d,
            input logic [63:0] s, input bit e);
        int          bits;
        logic [63:0] z;
        logic [63:0] x;
        bit          take;
        if (!v) return cur;
        if (op < 12'h038 || op > 12'h03F) return cur + 64'd1;
        case (sz)
            2'd0: bits = 8;
            2'd1: bits = 16;
            2'd2: bits = 32;
            default: bits = 64;
        endcase
        for (int i = 0; i < 64; i++) begin
            z[i] = (i < bits) ? d[i] : 1'b0;
            x[i] = (i < bits) ? d[i] : d[bits-1];
        end
        case (op)
            12'h038, 12'h03C: take = 1'b1;
            12'h039, 12'h03D: take = e;
            12'h03A, 12'h03E: take = !e;
            default:          take = (s != 64'd0);
        endcase
        if (!take) return cur + 64'd1;
        if (op >= 12'h03C) return cur + x;
        return z;
    endfunction

    function automatic string req_of(input bit v, input logic [11:0] op);
        if (!v) return "R2";
        case (op)
            12'h038:          return "R4";
            12'h039, 12'h03A: return "R5";
            12'h03B:          return "R6";
            12'h03C:          return "R7";
            12'h03D, 12'h03E: return "R8";
            12'h03F:          return "R9";
            default:          return "R3";
        endcase
    endfunction

    task automatic check_now();
        n_cmp++;
        if (pc !== exp_pc) begin
            n_bad++;
            $display("FAIL %s: pc actual %h expected %h", exp_tag, pc, exp_pc);
        end
    endtask

    task automatic drive(input bit v, input logic [11:0] op, input logic [1:0] sz,
            input logic [63:0] d, input logic [63:0] s, input bit e, input string tag = "");
        @(negedge clk);
        check_now();
        instr_valid = v;
        opcode      = op;
        size_sel    = sz;
        dst_opnd    = d;
        src_opnd    = s;
        eq_flag     = e;
        exp_pc      = ref_next(exp_pc, v, op, sz, d, s, e);
        exp_tag     = (tag == "") ? req_of(v, op) : tag;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds 0 despite a valid jump on the inputs
        instr_valid = 1'b1;
        opcode      = 12'h038;
        dst_opnd    = 64'h55;
        repeat (3) begin
            @(negedge clk);
            check_now();
        end
        @(negedge clk);
        check_now();
        rst_n       = 1'b1;
        instr_valid = 1'b0;
        exp_tag     = "R1";

        // R2: idle with branch fields present
        drive(0, 12'h038, 2'd3, 64'hDEAD, 64'h1, 1);
        drive(0, 12'h03C, 2'd0, 64'h10, 64'h0, 0);
        // R3: non-branch opcodes
        drive(1, 12'h037, 2'd0, 64'hFF, 64'h1, 1);
        drive(1, 12'h040, 2'd3, 64'hFF, 64'h1, 1);
        drive(1, 12'h0B8, 2'd0, 64'h12, 64'h1, 1);
        drive(1, 12'h000, 2'd1, 64'h0, 64'h0, 0);
        // R4: each width, garbage above
        drive(1, 12'h038, 2'd0, 64'hFFFF_FFFF_FFFF_FF9A, 64'h0, 0);
        drive(1, 12'h038, 2'd1, 64'hABCD_0000_0000_8123, 64'h0, 0);
        drive(1, 12'h038, 2'd2, 64'h1111_2222_9876_5432, 64'h0, 1);
        drive(1, 12'h038, 2'd3, 64'h0123_4567_89AB_CDEF, 64'h0, 0);
        drive(1, 12'h038, 2'd0, 64'h0, 64'h0, 0);
        // R5: equal-flag absolute jumps, source set against the condition
        drive(1, 12'h039, 2'd1, 64'h4000, 64'h0, 0);
        drive(1, 12'h039, 2'd1, 64'h4000, 64'h0, 1);
        drive(1, 12'h03A, 2'd0, 64'h77, 64'h5, 1);
        drive(1, 12'h03A, 2'd0, 64'h77, 64'h0, 0);
        // R6: source-tested absolute jump
        drive(1, 12'h03B, 2'd0, 64'h20, 64'h0, 1);
        drive(1, 12'h03B, 2'd0, 64'h20, 64'h8000_0000_0000_0000, 0);
        // R7: relative, positive and negative, each width
        drive(1, 12'h03C, 2'd0, 64'h0000_0000_0000_0010, 64'h0, 0);
        drive(1, 12'h03C, 2'd0, 64'h1234_0000_0000_00F0, 64'h0, 0);
        drive(1, 12'h03C, 2'd1, 64'hFFFF_0000_0000_8000, 64'h0, 1);
        drive(1, 12'h03C, 2'd1, 64'h0000_0000_0000_7FFF, 64'h0, 1);
        drive(1, 12'h03C, 2'd2, 64'h0000_0000_FFFF_FFFE, 64'h0, 0);
        drive(1, 12'h03C, 2'd3, 64'hFFFF_FFFF_FFFF_FF00, 64'h0, 0);
        drive(1, 12'h03C, 2'd0, 64'h0, 64'h0, 0);
        // R8: equal-flag relative
        drive(1, 12'h03D, 2'd0, 64'h08, 64'h0, 1);
        drive(1, 12'h03D, 2'd0, 64'h08, 64'h1, 0);
        drive(1, 12'h03E, 2'd0, 64'hFC, 64'h0, 0);
        drive(1, 12'h03E, 2'd0, 64'hFC, 64'h0, 1);
        // R9: source-tested relative
        drive(1, 12'h03F, 2'd0, 64'h40, 64'h0, 1);
        drive(1, 12'h03F, 2'd0, 64'h40, 64'h0000_0100_0000_0000, 0);
        // R10: wrap on step and on displacement
        drive(1, 12'h038, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0);
        drive(1, 12'h001, 2'd0, 64'h0, 64'h0, 0, "R10");
        drive(1, 12'h038, 2'd0, 64'h05, 64'h0, 0);
        drive(1, 12'h03C, 2'd0, 64'hF8, 64'h0, 0, "R10");
        drive(1, 12'h03C, 2'd0, 64'h0A, 64'h0, 0, "R10");
        // mixed traffic around the branch group
        for (int k = 0; k < 400; k++) begin
            logic [63:0] s;
            s = ($urandom_range(0, 2) == 0) ? 64'h0 : {$urandom, $urandom};
            drive(bit'($urandom_range(0, 4) != 0),
                  12'(12'h034 + $urandom_range(0, 13)),
                  2'($urandom_range(0, 3)),
                  {$urandom, $urandom}, s, bit'($urandom_range(0, 1)));
        end
        @(negedge clk);
        check_now();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule